// File: doc/BRIEF.md
# Segmented Read Cache with Line Lockdown

This block is a read-only instruction/data cache split into four segments. Each segment holds 64 lines of four 32-bit words, and any line of a segment may hold any address that maps to it, so a lookup compares the tag against all 64 lines of the addressed segment. On a miss the block requests the whole 16-byte line from external memory, writes the four returning words into a chosen line, and then answers the requester. A forced-fill request does the same lookup and refill but returns no data, so software can preload lines.

Line choice on a miss is governed by a lockdown register. When its lock bit is set, every refill goes to the line named by the register's index in the addressed segment. When the lock bit is clear, a victim counter picks the line, and that counter only runs from the index up to 63. Lines below the index are therefore pinned. Software flushes the cache, sets the lock bit, walks the index upward while force-filling the code or data it wants to keep, and finally clears the lock bit with the index left one past the last pinned line.

Top module: `lkc_cache`

## Requirements
- R1: After reset no line is valid (the first read of any address misses), the lockdown register reads 0, `busy_o`, `rsp_done_o` and `mem_req_o` are low, and the victim counter is 0.
- R2: Byte address bits [5:4] select the segment and bits [3:2] the word within a line; lines in different segments are independent, and a read returns the word selected by bits [3:2].
- R3: On a miss, `mem_req_o` is a one-cycle pulse in the cycle after the request is taken, with `mem_addr_o` equal to the request address with bits [3:0] cleared; four words are taken in order on `mem_rvalid_i`, and `rsp_done_o` pulses in the cycle after the fourth word; `busy_o` is high from the cycle after acceptance until that pulse, during which requests are not taken.
- R4: A read that hits raises `rsp_done_o` and `rsp_valid_o` in the cycle after acceptance with the cached word, and raises no memory request.
- R5: A forced fill (`req_fill_i`=1) that misses refills the line like a read, but its completion pulse has `rsp_valid_o`=0; the line then hits.
- R6: The lockdown register is written through `lk_wr_i`/`lk_wdata_i`; bit 31 is the lock bit, bits [5:0] the index, and every other bit reads back as 0 on `lk_rdata_o`.
- R7: While the lock bit is 1 at the time a miss is taken, the refill goes to the line at the index in the addressed segment and the victim counter does not move.
- R8: The victim counter advances by one on each completed refill taken with the lock bit 0, wraps from 63 to the index, and is set to the written index on every lockdown write; lines below the index are never replaced by such refills.
- R9: `flush_i` clears every valid bit, so every address misses afterwards.
- R10: When a lockdown write falls in the cycle a non-locked refill completes, the write wins: the victim counter takes the new index instead of advancing.
- R11: A read or forced fill that hits changes neither the cache contents nor the victim counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present; taken when `busy_o` is low |
| req_fill_i | input | 1 | 1 = forced fill (no data returned), 0 = read |
| req_addr_i | input | 32 | Byte address of the request |
| busy_o | output | 1 | A refill is in progress; requests are not taken |
| rsp_done_o | output | 1 | One-cycle pulse: request finished |
| rsp_valid_o | output | 1 | With `rsp_done_o`: `rsp_data_o` carries read data |
| rsp_data_o | output | 32 | Read data |
| lk_wr_i | input | 1 | Lockdown register write strobe |
| lk_wdata_i | input | 32 | Lockdown write value (bit 31 lock, bits 5:0 index) |
| lk_rdata_o | output | 32 | Lockdown register contents |
| flush_i | input | 1 | Invalidate all lines |
| mem_req_o | output | 1 | One-cycle line fetch request |
| mem_addr_o | output | 32 | Line-aligned fetch address |
| mem_rvalid_i | input | 1 | Refill word strobe |
| mem_rdata_i | input | 32 | Refill word, in address order |

## Verification
The end of a non-locked refill moves the victim counter, and a software write to the lockdown register also loads it, so both can land on the same clock edge. The bench arranges this by driving the lockdown write alongside the fourth refill word, after first setting an index below the new one. It then judges the outcome only through the ports: it fills exactly as many distinct lines as lie between the new index and 63, plus one, and expects the first of them to miss again, which happens only if the counter restarted at the new index; the line filled during the collision, which sits below the new index, must still hit.

// File: rtl/lkc_pkg.sv
package lkc_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } lkc_state_e;

    localparam int unsigned LK_REG_W   = 32;
    localparam int unsigned LK_LOCK_BIT = 31;
endpackage

// File: rtl/lkc_match.sv
module lkc_match #(
    parameter int unsigned LINES = 64,
    parameter int unsigned TAG_W = 26,
    localparam int unsigned IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0][TAG_W-1:0] tags_i,
    input  logic [LINES-1:0]            valid_i,
    input  logic [TAG_W-1:0]            tag_i,
    output logic                        hit_o,
    output logic [IDX_W-1:0]            idx_o
);
    logic [LINES-1:0] eq_vec;

    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign eq_vec[g] = valid_i[g] && (tags_i[g] == tag_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < LINES; i++) begin
            if (eq_vec[i]) idx_o = IDX_W'(i);
        end
    end

    assign hit_o = |eq_vec;
endmodule

// File: rtl/lkc_victim.sv
module lkc_victim #(
    parameter int unsigned LINES = 64,
    localparam int unsigned IDX_W = $clog2(LINES)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             advance_i,
    input  logic             load_i,
    input  logic [IDX_W-1:0] load_idx_i,
    input  logic [IDX_W-1:0] floor_i,
    output logic [IDX_W-1:0] victim_o
);
    logic [IDX_W-1:0] vict_d, vict_q;

    always_comb begin
        vict_d = vict_q;
        if (load_i) begin
            vict_d = load_idx_i;
        end else if (advance_i) begin
            vict_d = (vict_q == IDX_W'(LINES - 1)) ? floor_i : vict_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) vict_q <= '0;
        else         vict_q <= vict_d;
    end

    assign victim_o = vict_q;
endmodule

// File: rtl/lkc_store.sv
module lkc_store #(
    parameter int unsigned ENTRIES = 1024,
    parameter int unsigned DATA_W  = 32,
    localparam int unsigned AW     = $clog2(ENTRIES)
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem_q [ENTRIES];

    always_ff @(posedge clk_i) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/lkc_cache.sv
module lkc_cache #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEGS   = 4,
    parameter int unsigned LINES  = 64,
    parameter int unsigned WORDS  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic              req_fill_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              busy_o,
    output logic              rsp_done_o,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o,
    input  logic              lk_wr_i,
    input  logic [31:0]       lk_wdata_i,
    output logic [31:0]       lk_rdata_o,
    input  logic              flush_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i
);
    import lkc_pkg::*;

    localparam int unsigned BYTE_W  = $clog2(DATA_W / 8);
    localparam int unsigned WSEL_W  = $clog2(WORDS);
    localparam int unsigned OFF_W   = BYTE_W + WSEL_W;
    localparam int unsigned SEG_W   = $clog2(SEGS);
    localparam int unsigned IDX_W   = $clog2(LINES);
    localparam int unsigned TAG_W   = ADDR_W - OFF_W - SEG_W;
    localparam int unsigned ENTRIES = SEGS * LINES * WORDS;
    localparam int unsigned MA_W    = $clog2(ENTRIES);

    typedef struct packed {
        lkc_state_e        st;
        logic              lk_lock;
        logic [IDX_W-1:0]  lk_idx;
        logic [SEG_W-1:0]  fill_seg;
        logic [TAG_W-1:0]  fill_tag;
        logic [IDX_W-1:0]  fill_line;
        logic [WSEL_W-1:0] fill_word;
        logic              fill_read;
        logic              fill_locked;
        logic [WSEL_W-1:0] beat;
        logic              mem_req;
        logic              rsp_done;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
    } regs_t;

    regs_t d, q;

    logic [SEGS-1:0][LINES-1:0][TAG_W-1:0] tag_q;
    logic [SEGS-1:0][LINES-1:0]            valid_q;

    logic [SEG_W-1:0]  seg_in;
    logic [TAG_W-1:0]  tag_in;
    logic [WSEL_W-1:0] wsel_in;
    logic              accept;
    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  vict;
    logic [IDX_W-1:0]  target;
    logic              alloc;
    logic              fill_done;
    logic              fill_locked;
    logic              advance;
    logic              st_we;
    logic [DATA_W-1:0] st_rdata;
    logic              unused_bits;

    assign seg_in  = req_addr_i[OFF_W +: SEG_W];
    assign tag_in  = req_addr_i[ADDR_W-1 -: TAG_W];
    assign wsel_in = req_addr_i[BYTE_W +: WSEL_W];
    assign unused_bits = ^{lk_wdata_i[LK_REG_W-2:IDX_W], req_addr_i[BYTE_W-1:0]};

    assign accept = req_valid_i && (q.st == ST_IDLE);
    assign target = q.lk_lock ? q.lk_idx : vict;
    assign alloc  = accept && !hit;
    assign st_we  = (q.st == ST_FILL) && mem_rvalid_i;
    assign fill_done   = st_we && (q.beat == WSEL_W'(WORDS - 1));
    assign fill_locked = q.fill_locked;
    assign advance     = fill_done && !q.fill_locked;

    lkc_match #(.LINES(LINES), .TAG_W(TAG_W)) u_match (
        .tags_i  (tag_q[seg_in]),
        .valid_i (valid_q[seg_in]),
        .tag_i   (tag_in),
        .hit_o   (hit),
        .idx_o   (hit_idx)
    );

    lkc_victim #(.LINES(LINES)) u_victim (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .advance_i  (advance),
        .load_i     (lk_wr_i),
        .load_idx_i (lk_wdata_i[IDX_W-1:0]),
        .floor_i    (q.lk_idx),
        .victim_o   (vict)
    );

    lkc_store #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_store (
        .clk_i   (clk_i),
        .we_i    (st_we),
        .waddr_i (MA_W'({q.fill_seg, q.fill_line, q.beat})),
        .wdata_i (mem_rdata_i),
        .raddr_i (MA_W'({seg_in, hit_idx, wsel_in})),
        .rdata_o (st_rdata)
    );

    always_comb begin
        d           = q;
        d.mem_req   = 1'b0;
        d.rsp_done  = 1'b0;
        d.rsp_valid = 1'b0;

        if (accept) begin
            if (hit) begin
                d.rsp_done  = 1'b1;
                d.rsp_valid = !req_fill_i;
                d.rsp_data  = st_rdata;
            end else begin
                d.st          = ST_FILL;
                d.mem_req     = 1'b1;
                d.fill_seg    = seg_in;
                d.fill_tag    = tag_in;
                d.fill_line   = target;
                d.fill_word   = wsel_in;
                d.fill_read   = !req_fill_i;
                d.fill_locked = q.lk_lock;
                d.beat        = '0;
            end
        end

        if (st_we) begin
            if (q.fill_read && (q.beat == q.fill_word)) d.rsp_data = mem_rdata_i;
            d.beat = q.beat + 1'b1;
            if (fill_done) begin
                d.st        = ST_IDLE;
                d.rsp_done  = 1'b1;
                d.rsp_valid = q.fill_read;
            end
        end

        if (lk_wr_i) begin
            d.lk_lock = lk_wdata_i[LK_LOCK_BIT];
            d.lk_idx  = lk_wdata_i[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            valid_q <= '0;
        end else if (flush_i) begin
            valid_q <= '0;
        end else begin
            if (alloc)     valid_q[seg_in][target] <= 1'b0;
            if (fill_done) valid_q[q.fill_seg][q.fill_line] <= 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (alloc) tag_q[seg_in][target] <= tag_in;
    end

    assign busy_o      = (q.st == ST_FILL);
    assign rsp_done_o  = q.rsp_done;
    assign rsp_valid_o = q.rsp_valid;
    assign rsp_data_o  = q.rsp_data;
    assign mem_req_o   = q.mem_req;
    assign mem_addr_o  = {q.fill_tag, q.fill_seg, {OFF_W{1'b0}}};
    assign lk_rdata_o  = {q.lk_lock, {(LK_REG_W-1-IDX_W){1'b0}}, q.lk_idx};
endmodule

// File: rtl/lkc_cache_chk.sv
module lkc_cache_chk #(
    parameter int unsigned IDX_W = 6
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             accept,
    input logic             hit,
    input logic             busy,
    input logic             mem_req,
    input logic             rsp_done,
    input logic             fill_done,
    input logic             fill_locked,
    input logic             lk_wr,
    input logic [IDX_W-1:0] lk_widx,
    input logic [IDX_W-1:0] lk_idx,
    input logic [IDX_W-1:0] vict
);
    assert_req_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req |=> !mem_req);

    assert_miss_fetch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept && !hit) |=> (mem_req && busy));

    assert_done_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_done |-> !busy);

    assert_hit_nomem_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept && hit) |=> (rsp_done && !mem_req));

    assert_lock_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fill_done && fill_locked && !lk_wr) |=> $stable(vict));

    assert_victim_floor_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vict >= lk_idx);

    assert_write_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_wr |=> (vict == $past(lk_widx)));

    assert_hit_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept && hit && !lk_wr && !fill_done) |=> $stable(vict));
endmodule

bind lkc_cache lkc_cache_chk #(.IDX_W(IDX_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept      (accept),
    .hit         (hit),
    .busy        (busy_o),
    .mem_req     (mem_req_o),
    .rsp_done    (rsp_done_o),
    .fill_done   (fill_done),
    .fill_locked (fill_locked),
    .lk_wr       (lk_wr_i),
    .lk_widx     (lk_wdata_i[IDX_W-1:0]),
    .lk_idx      (lk_rdata_o[IDX_W-1:0]),
    .vict        (vict)
);

// File: tb/test_lkc_cache.sv
`timescale 1ns/1ps
module test_lkc_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_fill = 1'b0;
    logic [31:0] req_addr = '0;
    logic        busy, rsp_done, rsp_valid;
    logic [31:0] rsp_data;
    logic        lk_wr = 1'b0;
    logic [31:0] lk_wdata = '0;
    logic [31:0] lk_rdata;
    logic        flush = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    lkc_cache i_lkc_cache (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_fill_i(req_fill), .req_addr_i(req_addr),
        .busy_o(busy), .rsp_done_o(rsp_done), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
        .lk_wr_i(lk_wr), .lk_wdata_i(lk_wdata), .lk_rdata_o(lk_rdata),
        .flush_i(flush),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
    );

    function automatic logic [31:0] mword(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h3C3C_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One request; serves the refill when it misses. Optionally a lockdown
    // write is driven together with the fourth refill word.
    task automatic access(input logic [31:0] a, input bit ff, input bit lk_last,
                          input logic [31:0] lk_val, output bit hit,
                          output bit dv, output logic [31:0] dat);
        logic [31:0] line;
        line = {a[31:4], 4'h0};
        @(negedge clk);
        req_valid = 1'b1; req_fill = ff; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (rsp_done) begin
            hit = 1'b1; dv = rsp_valid; dat = rsp_data;
            chk(!mem_req, "R4 no fetch on hit", {31'd0, mem_req}, 32'd0);
        end else begin
            hit = 1'b0;
            chk(mem_req && busy, "R3 fetch pulse and busy", {30'd0, mem_req, busy}, 32'd3);
            chk(mem_addr == line, "R3 line-aligned address", mem_addr, line);
            for (int w = 0; w < 4; w++) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mword(line | (w << 2));
                if (w == 3 && lk_last) begin lk_wr = 1'b1; lk_wdata = lk_val; end
                @(negedge clk);
                lk_wr = 1'b0;
                if (w == 0) chk(!mem_req, "R3 fetch is one cycle", {31'd0, mem_req}, 32'd0);
                if (w < 3) chk(busy && !rsp_done, "R3 busy until done", {30'd0, busy, rsp_done}, 32'd2);
            end
            mem_rvalid = 1'b0;
            chk(rsp_done && !busy, "R3 done after fourth word", {30'd0, rsp_done, busy}, 32'd2);
            dv = rsp_valid; dat = rsp_data;
        end
    endtask

    task automatic rd(input logic [31:0] a, output bit hit, output bit dv, output logic [31:0] dat);
        access(a, 1'b0, 1'b0, 32'd0, hit, dv, dat);
    endtask

    task automatic ffill(input logic [31:0] a, output bit hit, output bit dv);
        logic [31:0] dat;
        access(a, 1'b1, 1'b0, 32'd0, hit, dv, dat);
    endtask

    task automatic lk_write(input logic [31:0] v);
        @(negedge clk); lk_wr = 1'b1; lk_wdata = v;
        @(negedge clk); lk_wr = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic t_reset();
        bit h, v; logic [31:0] dat;
        chk(lk_rdata == 32'd0, "R1 lockdown reads 0", lk_rdata, 32'd0);
        chk(!busy && !rsp_done && !mem_req, "R1 outputs idle",
            {29'd0, busy, rsp_done, mem_req}, 32'd0);
        rd(32'h0000_0100, h, v, dat);
        chk(!h, "R1 first read misses", {31'd0, h}, 32'd0);
    endtask

    task automatic t_miss_hit();
        bit h, v; logic [31:0] dat;
        rd(32'h0000_1238, h, v, dat);
        chk(!h && v && dat == mword(32'h0000_1238), "R3 miss returns word", dat, mword(32'h0000_1238));
        rd(32'h0000_1234, h, v, dat);
        chk(h && v && dat == mword(32'h0000_1234), "R4 hit returns word", dat, mword(32'h0000_1234));
    endtask

    task automatic t_segments();
        bit h, v; logic [31:0] dat;
        for (int s = 0; s < 4; s++) rd(32'h0000_4000 + s * 16, h, v, dat);
        for (int s = 0; s < 4; s++) begin
            rd(32'h0000_4004 + s * 16 + (s % 2) * 8, h, v, dat);
            chk(h && dat == mword(32'h0000_4004 + s * 16 + (s % 2) * 8),
                "R2 segment lines independent", dat, mword(32'h0000_4004 + s * 16 + (s % 2) * 8));
        end
    endtask

    task automatic t_force();
        bit h, v; logic [31:0] dat;
        ffill(32'h0000_8000, h, v);
        chk(!h && !v, "R5 forced fill returns no data", {30'd0, h, v}, 32'd0);
        rd(32'h0000_800C, h, v, dat);
        chk(h && dat == mword(32'h0000_800C), "R5 preloaded line hits", dat, mword(32'h0000_800C));
        ffill(32'h0000_8008, h, v);
        chk(h && !v, "R11 forced fill hit no data", {30'd0, h, v}, 32'd2);
        rd(32'h0000_8000, h, v, dat);
        chk(h && dat == mword(32'h0000_8000), "R11 contents unchanged after hit", dat, mword(32'h0000_8000));
    endtask

    task automatic t_lkreg();
        lk_write(32'hFFFF_FFC5);
        chk(lk_rdata == 32'h8000_0005, "R6 lock bit and index readback", lk_rdata, 32'h8000_0005);
        lk_write(32'h0000_0040);
        chk(lk_rdata == 32'h0000_0000, "R6 other bits read 0", lk_rdata, 32'h0);
    endtask

    task automatic t_flush();
        bit h, v; logic [31:0] dat;
        do_flush();
        rd(32'h0000_1234, h, v, dat);
        chk(!h, "R9 flush invalidates", {31'd0, h}, 32'd0);
    endtask

    task automatic t_lock();
        bit h, v; logic [31:0] dat;
        do_flush();
        lk_write(32'h8000_0000);
        ffill(32'h0001_0000, h, v);
        lk_write(32'h8000_0001);
        ffill(32'h0001_0040, h, v);
        lk_write(32'h0000_0002);
        for (int k = 0; k < 124; k++) ffill(32'h0002_0000 + k * 64, h, v);
        rd(32'h0001_0004, h, v, dat);
        chk(h && dat == mword(32'h0001_0004), "R7 locked line 0 kept", dat, mword(32'h0001_0004));
        rd(32'h0001_0048, h, v, dat);
        chk(h && dat == mword(32'h0001_0048), "R7 locked line 1 kept", dat, mword(32'h0001_0048));
        rd(32'h0002_0000 + 123 * 64, h, v, dat);
        chk(h, "R8 latest fill present", {31'd0, h}, 32'd1);
        rd(32'h0002_0000, h, v, dat);
        chk(!h, "R8 victim wrapped to index", {31'd0, h}, 32'd0);
    endtask

    task automatic t_collide();
        bit h, v; logic [31:0] dat;
        do_flush();
        lk_write(32'h0000_0005);
        access(32'h0003_0000, 1'b0, 1'b1, 32'h0000_000A, h, v, dat);
        chk(lk_rdata == 32'h0000_000A, "R10 write taken with last word", lk_rdata, 32'h0000_000A);
        for (int k = 0; k < 55; k++) ffill(32'h0004_0000 + k * 64, h, v);
        rd(32'h0004_0000, h, v, dat);
        chk(!h, "R10 victim restarted at new index", {31'd0, h}, 32'd0);
        rd(32'h0003_0000, h, v, dat);
        chk(h && dat == mword(32'h0003_0000), "R8 line below index kept", dat, mword(32'h0003_0000));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_miss_hit();
        t_segments();
        t_force();
        t_lkreg();
        t_flush();
        t_lock();
        t_collide();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule